// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block sits in front of the two ALU operand inputs of a five-stage integer pipeline. It works out where each operand of the instruction now in execute should come from. The default source is the register-file value latched in the decode/execute register. A bypass source is used instead when an older instruction further down the pipe will write the register being read and has not yet written it back. There are three bypass sources:

- the ALU result held in the execute/memory register;
- the ALU result held in the memory/writeback register;
- the load data held in the memory/writeback register.

The block is purely combinational. It reads the three raw instruction words and the data fields that travel with them. For each operand it returns a 2-bit select and the chosen value. Stall generation and bypassing into the store-data or branch-test paths belong to neighbouring logic.

Top module: `alu_bypass_unit`

## Requirements
- R1: Instruction words are decoded as follows, and any other opcode neither produces nor consumes a bypass.
  - Field positions: opcode in bits 31:26, first source (rs) in 25:21, second source (rt) in 20:16, register-register destination (rd) in 15:11.
  - Opcode 0x00 is a register-register ALU op.
  - Opcodes 0x08 to 0x0F are ALU-immediate ops.
  - Opcode 0x23 is a load and 0x2B is a store.
  - Opcodes 0x04 and 0x05 are branches.
- R2: Each select uses the code 00 = register value from decode/execute, 01 = execute/memory ALU result, 10 = memory/writeback ALU result, 11 = memory/writeback load data. Each operand output equals the source its select names.
- R3: A register-register producer in execute/memory is matched through its rd field, and a match gives select 01.
- R4: An ALU-immediate producer is matched through its rt field. Its bits 15:11 are never used as a destination.
- R5: A load in execute/memory is never a bypass source for either operand.
- R6: A register-register (rd) or ALU-immediate (rt) producer in memory/writeback that matches gives select 10.
- R7: A load in memory/writeback whose rt matches gives select 11.
- R8: The bottom operand is compared against the consumer's rt only when the consumer is a register-register op. For any other consumer the bottom select is 00.
- R9: The top operand is compared against the consumer's rs when the consumer is a register-register, ALU-immediate, load, store or branch op. For any other consumer the top select is 00.
- R10: When both stages match the same operand, the execute/memory source wins.
- R11: A destination of register 0 is never forwarded.
- R12: With no match, both selects are 00 and the operands are the latched register values.
- R13: Store and branch instructions never act as producers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_ir | input | 32 | Instruction word of the consumer in execute |
| idex_rs_val | input | DATA_W | Register-file value read for rs |
| idex_rt_val | input | DATA_W | Register-file value read for rt |
| exmem_ir | input | 32 | Instruction word in execute/memory |
| exmem_alu_res | input | DATA_W | ALU result in execute/memory |
| memwb_ir | input | 32 | Instruction word in memory/writeback |
| memwb_alu_res | input | DATA_W | ALU result in memory/writeback |
| memwb_load_data | input | DATA_W | Load data in memory/writeback |
| sel_top | output | 2 | Source select for the top ALU operand |
| sel_bot | output | 2 | Source select for the bottom ALU operand |
| opnd_top | output | DATA_W | Selected top ALU operand |
| opnd_bot | output | DATA_W | Selected bottom ALU operand |

## Verification
Every stimulus pairs one consumer class with one producer class in each stage, and each data source carries a distinct value, so a wrong select shows up in the operand value as well as in the select itself.

Single-stage matches on the top and bottom operands separate the rd/rt destination choice and the four select codes. Patterns where both stages match show which stage has priority. Near-miss patterns show that each excluded case stays on the register path:
- a load in execute/memory;
- a store or branch as producer;
- a register-0 destination;
- an ALU-immediate whose immediate bits look like an rd;
- a non-register-register consumer on the bottom operand;
- an opcode just outside the ALU-immediate range.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
// Package fwd_pkg
// Shared field positions, opcode values, select codes and the instruction
// class decoder used by every module of the bypass selector.
// Assumes the fixed 32-bit three-format instruction layout.
package fwd_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int OPC_LSB = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;

    localparam logic [OPC_W-1:0] OPC_RR      = 6'h00;
    localparam logic [OPC_W-1:0] OPC_IMM_LO  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_IMM_HI  = 6'h0F;
    localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BR_EQZ  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BR_NEZ  = 6'h05;

    typedef enum logic [1:0] {
        SEL_REG     = 2'b00,
        SEL_EXM_ALU = 2'b01,
        SEL_MWB_ALU = 2'b10,
        SEL_MWB_LD  = 2'b11
    } fwd_sel_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_RR,
        CLS_IMM,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH
    } insn_cls_e;

    // Map an opcode to its instruction class.
    function automatic insn_cls_e classify(input logic [OPC_W-1:0] opc);
        insn_cls_e c;
        if (opc == OPC_RR)
            c = CLS_RR;
        else if (opc >= OPC_IMM_LO && opc <= OPC_IMM_HI)
            c = CLS_IMM;
        else if (opc == OPC_LOAD)
            c = CLS_LOAD;
        else if (opc == OPC_STORE)
            c = CLS_STORE;
        else if (opc == OPC_BR_EQZ || opc == OPC_BR_NEZ)
            c = CLS_BRANCH;
        else
            c = CLS_NONE;
        return c;
    endfunction

    function automatic logic [OPC_W-1:0] opc_of(input logic [INSN_W-1:0] ir);
        return ir[OPC_LSB +: OPC_W];
    endfunction

    function automatic logic [REG_W-1:0] rs_of(input logic [INSN_W-1:0] ir);
        return ir[RS_LSB +: REG_W];
    endfunction

    function automatic logic [REG_W-1:0] rt_of(input logic [INSN_W-1:0] ir);
        return ir[RT_LSB +: REG_W];
    endfunction

    function automatic logic [REG_W-1:0] rd_of(input logic [INSN_W-1:0] ir);
        return ir[RD_LSB +: REG_W];
    endfunction

endpackage

// File: rtl/fwd_producer.sv
`timescale 1ns/1ps
// Module fwd_producer
// Decodes one downstream instruction word into a register-write intent:
// whether it writes a register that may be bypassed, which register, and
// whether the value is load data. The destination is rd for register-register
// ops and rt for ALU-immediate ops and loads. Stores, branches and unknown
// opcodes write nothing. Register 0 is never reported as a destination.
// ALLOW_LOAD = 0 removes loads as a source (used for the execute/memory stage,
// whose load data does not exist yet).
module fwd_producer
    import fwd_pkg::*;
#(
    parameter bit ALLOW_LOAD = 1'b1
) (
    input  logic [INSN_W-1:0] ir,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_idx,
    output logic              is_load
);

    insn_cls_e  cls;
    logic       base_en;
    logic       unused_ir;

    assign unused_ir = ^ir;

    // Classify the producer and pick its destination field.
    always_comb begin
        cls     = classify(opc_of(ir));
        base_en = 1'b0;
        wr_idx  = '0;
        case (cls)
            CLS_RR: begin
                base_en = 1'b1;
                wr_idx  = rd_of(ir);
            end
            CLS_IMM: begin
                base_en = 1'b1;
                wr_idx  = rt_of(ir);
            end
            CLS_LOAD: begin
                base_en = 1'b0;
                wr_idx  = rt_of(ir);
            end
            default: begin
                base_en = 1'b0;
                wr_idx  = '0;
            end
        endcase
    end

    generate
        if (ALLOW_LOAD) begin : g_load_src
            // Loads count as producers in this stage.
            always_comb begin
                is_load = (cls == CLS_LOAD);
                wr_en   = (base_en || is_load) && (wr_idx != '0);
            end
        end else begin : g_no_load_src
            // Loads are excluded as producers in this stage.
            always_comb begin
                is_load = 1'b0;
                wr_en   = base_en && (wr_idx != '0);
            end
        end
    endgenerate

endmodule

// File: rtl/fwd_mux4.sv
`timescale 1ns/1ps
// Module fwd_mux4
// Four-input operand multiplexer steered by a bypass select code.
// Assumes the select encoding defined in fwd_pkg.
module fwd_mux4
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] in_reg,
    input  logic [DATA_W-1:0] in_exm_alu,
    input  logic [DATA_W-1:0] in_mwb_alu,
    input  logic [DATA_W-1:0] in_mwb_ld,
    output logic [DATA_W-1:0] out
);

    // Route the selected source to the operand.
    always_comb begin
        case (sel)
            SEL_EXM_ALU: out = in_exm_alu;
            SEL_MWB_ALU: out = in_mwb_alu;
            SEL_MWB_LD:  out = in_mwb_ld;
            default:     out = in_reg;
        endcase
    end

endmodule

// File: rtl/fwd_operand_path.sv
`timescale 1ns/1ps
// Module fwd_operand_path
// Bypass decision and multiplexer for one ALU operand.
// BOTTOM = 0 selects the top operand: the consumer's rs field is compared
// for register-register, ALU-immediate, load, store and branch consumers.
// BOTTOM = 1 selects the bottom operand: the consumer's rt field is compared
// for register-register consumers only.
// Execute/memory matches take priority over memory/writeback matches.
module fwd_operand_path
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit BOTTOM = 1'b0
) (
    input  logic [INSN_W-1:0] consumer_ir,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] exm_alu,
    input  logic [DATA_W-1:0] mwb_alu,
    input  logic [DATA_W-1:0] mwb_ld,
    input  logic              exm_wr_en,
    input  logic [REG_W-1:0]  exm_wr_idx,
    input  logic              mwb_wr_en,
    input  logic [REG_W-1:0]  mwb_wr_idx,
    input  logic              mwb_is_load,
    output logic [1:0]        sel,
    output logic [DATA_W-1:0] opnd
);

    insn_cls_e  cls;
    logic       uses_src;
    logic [REG_W-1:0] src_idx;
    logic       exm_hit;
    logic       mwb_hit;
    fwd_sel_e   sel_e;
    logic       unused_ir;

    assign unused_ir = ^consumer_ir;
    assign cls       = classify(opc_of(consumer_ir));

    generate
        if (BOTTOM) begin : g_bottom
            // Bottom operand reads rt, only for register-register consumers.
            always_comb begin
                src_idx  = rt_of(consumer_ir);
                uses_src = (cls == CLS_RR);
            end
        end else begin : g_top
            // Top operand reads rs for every operand-using class.
            always_comb begin
                src_idx  = rs_of(consumer_ir);
                uses_src = (cls == CLS_RR) || (cls == CLS_IMM) ||
                           (cls == CLS_LOAD) || (cls == CLS_STORE) ||
                           (cls == CLS_BRANCH);
            end
        end
    endgenerate

    // Compare each stage's destination with the source register.
    always_comb begin
        exm_hit = uses_src && exm_wr_en && (exm_wr_idx == src_idx);
        mwb_hit = uses_src && mwb_wr_en && (mwb_wr_idx == src_idx) && !exm_hit;
    end

    // Encode the winning source.
    always_comb begin
        if (exm_hit)
            sel_e = SEL_EXM_ALU;
        else if (mwb_hit)
            sel_e = mwb_is_load ? SEL_MWB_LD : SEL_MWB_ALU;
        else
            sel_e = SEL_REG;
    end

    assign sel = sel_e;

    fwd_mux4 #(
        .DATA_W(DATA_W)
    ) u_mux (
        .sel        (sel_e),
        .in_reg     (reg_val),
        .in_exm_alu (exm_alu),
        .in_mwb_alu (mwb_alu),
        .in_mwb_ld  (mwb_ld),
        .out        (opnd)
    );

endmodule

// File: rtl/alu_bypass_unit.sv
`timescale 1ns/1ps
// Module alu_bypass_unit
// Top of the ALU operand bypass selector. Decodes the execute/memory and
// memory/writeback instructions as producers, then builds one operand path
// for each ALU input. Purely combinational. Assumes the pipeline registers
// hold bubbles as all-zero words (register-register with destination 0).
module alu_bypass_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]       idex_ir,
    input  logic [DATA_W-1:0] idex_rs_val,
    input  logic [DATA_W-1:0] idex_rt_val,
    input  logic [31:0]       exmem_ir,
    input  logic [DATA_W-1:0] exmem_alu_res,
    input  logic [31:0]       memwb_ir,
    input  logic [DATA_W-1:0] memwb_alu_res,
    input  logic [DATA_W-1:0] memwb_load_data,
    output logic [1:0]        sel_top,
    output logic [1:0]        sel_bot,
    output logic [DATA_W-1:0] opnd_top,
    output logic [DATA_W-1:0] opnd_bot
);

    localparam int NUM_OPND = 2;

    logic              exm_wr_en;
    logic [REG_W-1:0]  exm_wr_idx;
    logic              unused_exm_load;
    logic              mwb_wr_en;
    logic [REG_W-1:0]  mwb_wr_idx;
    logic              mwb_is_load;

    logic [DATA_W-1:0] reg_val  [NUM_OPND];
    logic [1:0]        sel_w    [NUM_OPND];
    logic [DATA_W-1:0] opnd_w   [NUM_OPND];

    fwd_producer #(
        .ALLOW_LOAD(1'b0)
    ) u_exm_prod (
        .ir      (exmem_ir),
        .wr_en   (exm_wr_en),
        .wr_idx  (exm_wr_idx),
        .is_load (unused_exm_load)
    );

    fwd_producer #(
        .ALLOW_LOAD(1'b1)
    ) u_mwb_prod (
        .ir      (memwb_ir),
        .wr_en   (mwb_wr_en),
        .wr_idx  (mwb_wr_idx),
        .is_load (mwb_is_load)
    );

    assign reg_val[0] = idex_rs_val;
    assign reg_val[1] = idex_rt_val;

    generate
        for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
            fwd_operand_path #(
                .DATA_W (DATA_W),
                .BOTTOM (g == 1)
            ) u_path (
                .consumer_ir (idex_ir),
                .reg_val     (reg_val[g]),
                .exm_alu     (exmem_alu_res),
                .mwb_alu     (memwb_alu_res),
                .mwb_ld      (memwb_load_data),
                .exm_wr_en   (exm_wr_en),
                .exm_wr_idx  (exm_wr_idx),
                .mwb_wr_en   (mwb_wr_en),
                .mwb_wr_idx  (mwb_wr_idx),
                .mwb_is_load (mwb_is_load),
                .sel         (sel_w[g]),
                .opnd        (opnd_w[g])
            );
        end
    endgenerate

    assign sel_top  = sel_w[0];
    assign sel_bot  = sel_w[1];
    assign opnd_top = opnd_w[0];
    assign opnd_bot = opnd_w[1];

endmodule

// File: rtl/alu_bypass_unit_chk.sv
`timescale 1ns/1ps
// Module alu_bypass_unit_chk
// Port-level checks for alu_bypass_unit, attached by bind. The block is
// combinational, so the checks are immediate assertions on settled values.
module alu_bypass_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic [31:0]       idex_ir,
    input logic [DATA_W-1:0] idex_rs_val,
    input logic [DATA_W-1:0] idex_rt_val,
    input logic [31:0]       exmem_ir,
    input logic [DATA_W-1:0] exmem_alu_res,
    input logic [31:0]       memwb_ir,
    input logic [DATA_W-1:0] memwb_alu_res,
    input logic [DATA_W-1:0] memwb_load_data,
    input logic [1:0]        sel_top,
    input logic [1:0]        sel_bot,
    input logic [DATA_W-1:0] opnd_top,
    input logic [DATA_W-1:0] opnd_bot
);

    // Check select/operand consistency and the exclusion rules.
    always_comb begin
        // R2
        opnd_top_src_chk: assert (opnd_top == (sel_top == 2'b00 ? idex_rs_val :
                                               sel_top == 2'b01 ? exmem_alu_res :
                                               sel_top == 2'b10 ? memwb_alu_res :
                                                                  memwb_load_data));
        // R2
        opnd_bot_src_chk: assert (opnd_bot == (sel_bot == 2'b00 ? idex_rt_val :
                                               sel_bot == 2'b01 ? exmem_alu_res :
                                               sel_bot == 2'b10 ? memwb_alu_res :
                                                                  memwb_load_data));
        // R5
        exm_load_blocked_chk: assert (!(exmem_ir[31:26] == 6'h23 &&
                                        (sel_top == 2'b01 || sel_bot == 2'b01)));
        // R7
        mwb_load_only_chk: assert (!((sel_top == 2'b11 || sel_bot == 2'b11) &&
                                     memwb_ir[31:26] != 6'h23));
        // R8
        bot_only_rr_chk: assert (!(idex_ir[31:26] != 6'h00 && sel_bot != 2'b00));
        // R11
        no_r0_top_chk: assert (!(sel_top != 2'b00 && idex_ir[25:21] == 5'd0));
        // R10
        nearer_wins_chk: assert (!(sel_top[1] && exmem_ir[31:26] == 6'h00 &&
                                   exmem_ir[15:11] == idex_ir[25:21]));
    end

endmodule

bind alu_bypass_unit alu_bypass_unit_chk #(
    .DATA_W(DATA_W)
) i_alu_bypass_unit_chk (
    .idex_ir         (idex_ir),
    .idex_rs_val     (idex_rs_val),
    .idex_rt_val     (idex_rt_val),
    .exmem_ir        (exmem_ir),
    .exmem_alu_res   (exmem_alu_res),
    .memwb_ir        (memwb_ir),
    .memwb_alu_res   (memwb_alu_res),
    .memwb_load_data (memwb_load_data),
    .sel_top         (sel_top),
    .sel_bot         (sel_bot),
    .opnd_top        (opnd_top),
    .opnd_bot        (opnd_bot)
);

// File: tb/test_alu_bypass_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task applies a pattern and queues the expected
// selects; the monitor pops at the falling edge and compares.
module test_alu_bypass_unit;

    localparam int DW = 32;
    localparam logic [DW-1:0] V_RS  = 32'hA000_0001;
    localparam logic [DW-1:0] V_RT  = 32'hB000_0002;
    localparam logic [DW-1:0] V_EXM = 32'hC000_0003;
    localparam logic [DW-1:0] V_MWA = 32'hD000_0004;
    localparam logic [DW-1:0] V_LD  = 32'hE000_0005;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done = 1'b0;
    int   checks = 0;
    int   errors = 0;

    logic [31:0]   idex_ir = '0, exmem_ir = '0, memwb_ir = '0;
    logic [1:0]    sel_top, sel_bot;
    logic [DW-1:0] opnd_top, opnd_bot;

    typedef struct {
        logic [1:0] st;
        logic [1:0] sb;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t cur;

    always #5 clk = ~clk;

    alu_bypass_unit #(.DATA_W(DW)) i_alu_bypass_unit (
        .idex_ir         (idex_ir),
        .idex_rs_val     (V_RS),
        .idex_rt_val     (V_RT),
        .exmem_ir        (exmem_ir),
        .exmem_alu_res   (V_EXM),
        .memwb_ir        (memwb_ir),
        .memwb_alu_res   (V_MWA),
        .memwb_load_data (V_LD),
        .sel_top         (sel_top),
        .sel_bot         (sel_bot),
        .opnd_top        (opnd_top),
        .opnd_bot        (opnd_bot)
    );

    function automatic logic [31:0] rr(input int rs, input int rt, input int rd);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
    endfunction

    function automatic logic [31:0] im(input logic [5:0] opc, input int rs,
                                       input int rt, input logic [15:0] imm);
        return {opc, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [DW-1:0] src_val(input logic [1:0] s, input bit bot);
        case (s)
            2'b01:   return V_EXM;
            2'b10:   return V_MWA;
            2'b11:   return V_LD;
            default: return bot ? V_RT : V_RS;
        endcase
    endfunction

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string what, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] c, input logic [31:0] e,
                         input logic [31:0] m, input logic [1:0] st,
                         input logic [1:0] sb, input string req);
        exp_t it;
        @(posedge clk);
        #1;
        idex_ir  = c;
        exmem_ir = e;
        memwb_ir = m;
        it.st = st; it.sb = sb; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: compare the outputs against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && q.size() != 0) begin
            cur = q.pop_front();
            check({30'd0, sel_top}, {30'd0, cur.st}, "sel_top", cur.req);
            check({30'd0, sel_bot}, {30'd0, cur.sb}, "sel_bot", cur.req);
            check(opnd_top, src_val(cur.st, 1'b0), "opnd_top R2", cur.req);
            check(opnd_bot, src_val(cur.sb, 1'b1), "opnd_bot R2", cur.req);
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R12: all bubbles, no match
        drive('0, '0, '0, 2'b00, 2'b00, "R12");
        drive(rr(1, 2, 3), rr(4, 5, 6), rr(7, 8, 9), 2'b00, 2'b00, "R12");
        // R3: register-register producer in EX/MEM, rd match
        drive(rr(3, 4, 1), rr(1, 2, 3), '0, 2'b01, 2'b00, "R3");
        drive(rr(5, 3, 1), rr(1, 2, 3), '0, 2'b00, 2'b01, "R3");
        // R4: ALU-immediate producer uses rt, never immediate bits as rd
        drive(rr(6, 6, 1), im(6'h08, 1, 6, 16'h0010), '0, 2'b01, 2'b01, "R4");
        drive(rr(7, 7, 1), im(6'h08, 1, 6, 16'h3800), '0, 2'b00, 2'b00, "R4");
        // R5: load in EX/MEM never forwards
        drive(rr(9, 9, 1), im(6'h23, 1, 9, 16'h0004), '0, 2'b00, 2'b00, "R5");
        drive(rr(9, 9, 1), im(6'h23, 1, 9, 16'h0004), rr(1, 2, 9), 2'b10, 2'b10, "R5");
        // R6: ALU results in MEM/WB
        drive(im(6'h0C, 10, 2, 16'h0001), '0, rr(1, 2, 10), 2'b10, 2'b00, "R6");
        drive(rr(1, 11, 2), '0, im(6'h09, 0, 11, 16'h0001), 2'b00, 2'b10, "R6");
        // R7: load data in MEM/WB
        drive(rr(12, 12, 1), '0, im(6'h23, 1, 12, 16'h0000), 2'b11, 2'b11, "R7");
        // R8: store and branch consumers use bottom register value
        drive(im(6'h2B, 12, 12, 16'h0000), '0, im(6'h23, 1, 12, 16'h0000), 2'b11, 2'b00, "R8");
        drive(im(6'h04, 13, 13, 16'h0002), rr(1, 2, 13), '0, 2'b01, 2'b00, "R8");
        // R9: top operand for a load consumer; none for an unknown opcode
        drive(im(6'h23, 14, 3, 16'h0000), rr(1, 2, 14), '0, 2'b01, 2'b00, "R9");
        drive(im(6'h02, 13, 13, 16'h0000), rr(1, 2, 13), '0, 2'b00, 2'b00, "R9");
        // R10: nearer stage wins; mixed stages per operand
        drive(rr(1, 1, 5), im(6'h08, 0, 1, 16'h0003), rr(2, 3, 1), 2'b01, 2'b01, "R10");
        drive(rr(1, 2, 5), rr(3, 4, 1), im(6'h23, 0, 2, 16'h0000), 2'b01, 2'b11, "R10");
        drive(rr(1, 1, 5), rr(3, 4, 1), im(6'h23, 0, 1, 16'h0000), 2'b01, 2'b01, "R10");
        // R11: register 0 destinations ignored
        drive(rr(0, 0, 5), rr(1, 2, 0), im(6'h23, 3, 0, 16'h0000), 2'b00, 2'b00, "R11");
        // R13: store and branch are not producers
        drive(rr(14, 14, 1), im(6'h2B, 1, 14, 16'h0000), im(6'h05, 14, 14, 16'h0000),
              2'b00, 2'b00, "R13");
        // R1: ALU-immediate opcode range boundaries
        drive(rr(15, 2, 1), im(6'h0F, 1, 15, 16'h0000), '0, 2'b01, 2'b00, "R1");
        drive(rr(15, 2, 1), im(6'h10, 1, 15, 16'h0000), '0, 2'b00, 2'b00, "R1");
        drive(rr(16, 2, 1), '0, im(6'h07, 1, 16, 16'h0000), 2'b00, 2'b00, "R1");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule